// File: doc/BRIEF.md
# Two-Rate Sinc4 Decimation Filter

This block converts the single-bit density stream of a delta-sigma modulator into signed 18-bit conversion results. Each modulator bit arrives with a one-clock `sample_en` strobe and counts as +1 when high and −1 when low. Four cascaded accumulators run at the sample rate. Four difference stages then run once per conversion, which gives a fourth-order sinc response with its notches at multiples of the output rate. Each notch holds four coincident zeros. A modulator running near 76.8 kHz, with the ratios 960 and 7680, gives notches at multiples of 80 Hz or of 10 Hz. The 10 Hz spacing rejects both 50 Hz and 60 Hz mains pickup.

The `speed` input selects the ratio of samples per result. High selects the short ratio (fast rate) and low selects the long ratio (slow rate). The raw filter sum is scaled by a right shift that depends on the ratio. It is then clamped to the 18-bit range, so an input beyond full scale pins the result at the extreme codes and never wraps. A change of `speed` empties the filter. The first four results after reset or after a change of rate are marked as not settled.

Top module: `sinc4_decimator`

## Requirements
- R1: While `rst_n` is low, `result` is 0, and `result_valid` and `result_settled` are 0.
- R2: A high `mod_bit` counts as +1 and a low one as −1. A stream with equal numbers of ones and zeros therefore yields code 0 once settled.
- R3: With `speed` high a result is produced every FAST_RATIO accepted samples, and with `speed` low every SLOW_RATIO. `result_valid` is a one-clock pulse two clocks after the edge that accepts the last sample of the period. `result` changes only on that pulse.
- R4: A settled result equals floor(N^4·m / 2^s), where N is the active ratio and m is the mean of the ±1 values over the filter window. s = floor(log2(N^4)) − 17. The result is two's complement in 18 bits, and each ratio must be at least 20.
- R5: Any scaled value above 131071 outputs 1FFFFh. A stream of all ones gives 1FFFFh.
- R6: Any scaled value below −131072 outputs 20000h. A stream of all zeros gives 20000h.
- R7: `result_settled` is 0 on the first four results after reset or after a change of `speed`, and 1 from the fifth result on.
- R8: After a step change in the input pattern, even one that arrives in the middle of a conversion, the fifth result after the step equals the settled value of the new pattern.
- R9: A change of `speed` clears the accumulators, the difference stages and the sample count. The edge on which the change is seen accepts no sample. Results then follow the new ratio from a fresh period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed | input | 1 | Rate select: 1 selects the short ratio, 0 selects the long ratio |
| sample_en | input | 1 | Strobe marking a valid modulator bit |
| mod_bit | input | 1 | Modulator output bit |
| result | output | 18 | Conversion result, two's complement |
| result_valid | output | 1 | One-clock pulse when a new result is presented |
| result_settled | output | 1 | High when the presented result has passed the four-result settling window |

## Verification
The bench builds the block with ratios of 24 and 48 rather than 960 and 7680. Both values give the same post-shift full-scale magnitude, 165888, so one table of expected codes serves both rates. These ratios let dozens of complete conversions, several rate changes and an input step in the middle of a conversion all run in a few thousand clocks. Periodic patterns whose period divides the ratio give exact settled codes that can be worked out by hand: zero, ± fractions of full scale, and densities that push past either clip level.

// File: rtl/sinc4_decimator.sv
module sinc4_decimator #(
  parameter int FAST_RATIO = 960,
  parameter int SLOW_RATIO = 7680,
  parameter int OUT_W      = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             speed,
  input  logic             sample_en,
  input  logic             mod_bit,
  output logic [OUT_W-1:0] result,
  output logic             result_valid,
  output logic             result_settled
);

  function automatic int floor_log2(longint v);
    int r = 0;
    while (v > 1) begin
      v = v >> 1;
      r++;
    end
    return r;
  endfunction

  localparam int     ACC_W   = 4 * $clog2(SLOW_RATIO + 1) + 1;
  localparam int     CNT_W   = $clog2(SLOW_RATIO);
  localparam longint FAST_P4 = longint'(FAST_RATIO) * FAST_RATIO * FAST_RATIO * FAST_RATIO;
  localparam longint SLOW_P4 = longint'(SLOW_RATIO) * SLOW_RATIO * SLOW_RATIO * SLOW_RATIO;
  localparam int     FAST_SH = floor_log2(FAST_P4) - (OUT_W - 1);
  localparam int     SLOW_SH = floor_log2(SLOW_P4) - (OUT_W - 1);
  localparam logic signed [ACC_W-1:0] TOP = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] BOT = ~TOP;

  logic                    speed_q, dec_stb;
  logic [CNT_W-1:0]        cnt;
  logic [2:0]              nres;
  logic signed [ACC_W-1:0] integ [4];
  logic signed [ACC_W-1:0] dly   [4];
  logic signed [ACC_W-1:0] c1, c2, c3, c4, scaled, step_v;
  logic [CNT_W-1:0]        last_idx;
  logic [OUT_W-1:0]        clipped;
  logic                    rate_chg;

  assign rate_chg = (speed != speed_q);
  assign step_v   = mod_bit ? ACC_W'(1) : {ACC_W{1'b1}};
  assign last_idx = speed_q ? CNT_W'(FAST_RATIO - 1) : CNT_W'(SLOW_RATIO - 1);

  assign c1 = integ[3] - dly[0];
  assign c2 = c1 - dly[1];
  assign c3 = c2 - dly[2];
  assign c4 = c3 - dly[3];

  assign scaled  = speed_q ? (c4 >>> FAST_SH) : (c4 >>> SLOW_SH);
  assign clipped = (scaled > TOP) ? TOP[OUT_W-1:0] :
                   (scaled < BOT) ? BOT[OUT_W-1:0] : scaled[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q        <= 1'b0;
      cnt            <= '0;
      dec_stb        <= 1'b0;
      nres           <= '0;
      result         <= '0;
      result_valid   <= 1'b0;
      result_settled <= 1'b0;
      for (int i = 0; i < 4; i++) begin
        integ[i] <= '0;
        dly[i]   <= '0;
      end
    end else begin
      result_valid <= 1'b0;
      dec_stb      <= 1'b0;
      if (rate_chg) begin
        speed_q <= speed;
        cnt     <= '0;
        nres    <= '0;
        for (int i = 0; i < 4; i++) begin
          integ[i] <= '0;
          dly[i]   <= '0;
        end
      end else begin
        if (sample_en) begin
          integ[0] <= integ[0] + step_v;
          for (int i = 1; i < 4; i++) integ[i] <= integ[i] + integ[i-1];
          if (cnt == last_idx) begin
            cnt     <= '0;
            dec_stb <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        if (dec_stb) begin
          dly[0]         <= integ[3];
          dly[1]         <= c1;
          dly[2]         <= c2;
          dly[3]         <= c3;
          result         <= clipped;
          result_valid   <= 1'b1;
          result_settled <= (nres == 3'd4);
          if (nres != 3'd4) nres <= nres + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sinc4_decimator_chk.sv
module sinc4_decimator_chk #(
  parameter int FAST_RATIO = 960,
  parameter int SLOW_RATIO = 7680,
  parameter int OUT_W      = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             speed,
  input logic             sample_en,
  input logic             mod_bit,
  input logic [OUT_W-1:0] result,
  input logic             result_valid,
  input logic             result_settled
);

  localparam int CNT_W = $clog2(SLOW_RATIO);

  logic             sq, chg, hit;
  logic [CNT_W-1:0] scnt, lastc;
  logic [2:0]       nv;
  logic             unused_in;

  assign unused_in = mod_bit;
  assign chg   = (speed != sq);
  assign lastc = sq ? CNT_W'(FAST_RATIO - 1) : CNT_W'(SLOW_RATIO - 1);
  assign hit   = sample_en && !chg && (scnt == lastc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq   <= 1'b0;
      scnt <= '0;
      nv   <= '0;
    end else if (chg) begin
      sq   <= speed;
      scnt <= '0;
      nv   <= '0;
    end else begin
      if (sample_en) scnt <= (scnt == lastc) ? '0 : scnt + 1'b1;
      if (result_valid && nv != 3'd4) nv <= nv + 1'b1;
    end
  end

  p_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit, 2) && !$past(chg)) |-> result_valid);
  p_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(hit, 2));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));
  p_unsettled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && nv != 3'd4) |-> !result_settled);
  p_settled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && nv == 3'd4) |-> result_settled);

endmodule

bind sinc4_decimator sinc4_decimator_chk #(
  .FAST_RATIO(FAST_RATIO), .SLOW_RATIO(SLOW_RATIO), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .speed(speed), .sample_en(sample_en),
  .mod_bit(mod_bit), .result(result), .result_valid(result_valid),
  .result_settled(result_settled)
);

// File: tb/sinc4_decimator_test.sv
module sinc4_decimator_test;
  localparam int FR = 24;
  localparam int SR = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        speed = 1'b0;
  logic        sample_en = 1'b0;
  logic        mod_bit = 1'b0;
  logic [17:0] result;
  logic        result_valid, result_settled;

  always #4 clk = ~clk;

  sinc4_decimator #(.FAST_RATIO(FR), .SLOW_RATIO(SR), .OUT_W(18)) uut (
    .clk(clk), .rst_n(rst_n), .speed(speed), .sample_en(sample_en),
    .mod_bit(mod_bit), .result(result), .result_valid(result_valid),
    .result_settled(result_settled)
  );

  // {speed, period, pattern (bit i = sample i mod period), settled code}
  // full-scale magnitude after the shift is 165888 for both ratios
  localparam logic [34:0] VEC [10] = '{
    {1'b1, 4'd2,  12'h001, 18'h00000},
    {1'b1, 4'd4,  12'h007, 18'h14400},
    {1'b0, 4'd4,  12'h001, 18'h2BC00},
    {1'b1, 4'd8,  12'h01F, 18'h0A200},
    {1'b0, 4'd3,  12'h003, 18'h0D800},
    {1'b1, 4'd6,  12'h001, 18'h25000},
    {1'b0, 4'd1,  12'h001, 18'h1FFFF},
    {1'b1, 4'd1,  12'h000, 18'h20000},
    {1'b1, 4'd12, 12'h7FF, 18'h1FFFF},
    {1'b0, 4'd8,  12'h07F, 18'h1E600}
  };

  int checks = 0, fails = 0;
  int idx = 0, scount = 0, cur_per = 1;
  bit ph = 1'b0;
  logic [11:0] cur_pat = '0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic idle();
    @(negedge clk);
    sample_en = 1'b0;
    ph = 1'b0;
    repeat (2) @(negedge clk);
    scount = 0;
    idx = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample_en = 1'b0;
    repeat (3) @(negedge clk);
    check(result == 18'h0, "R1", "reset result", result, 0);
    check(!result_valid, "R1", "reset valid", result_valid, 0);
    check(!result_settled, "R1", "reset settled", result_settled, 0);
    rst_n = 1'b1;
    idle();
  endtask

  task automatic drive(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sample_en = 1'b1;
      mod_bit = cur_pat[idx % cur_per];
      idx++;
      scount++;
      @(negedge clk);
      sample_en = 1'b0;
    end
    ph = 1'b0;
  endtask

  task automatic run(int nres, int first_chk, logic [17:0] exp, string req, bit fresh);
    int got = 0;
    int ratio = speed ? FR : SR;
    while (got < nres) begin
      @(negedge clk);
      if (result_valid) begin
        got++;
        check(scount == ratio, "R3", "samples per result", scount, ratio);
        scount = 0;
        if (fresh && got <= 4)
          check(!result_settled, "R7", "early settled flag", result_settled, 0);
        if (got >= first_chk) begin
          check(result == exp, req, "settled code", result, exp);
          check(result_settled, "R7", "settled flag", result_settled, 1);
        end
        if (got == nres) break;
      end
      if (ph) begin
        sample_en = 1'b1;
        mod_bit = cur_pat[idx % cur_per];
        idx++;
        scount++;
      end else begin
        sample_en = 1'b0;
      end
      ph = !ph;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int r = 0; r < 10; r++) begin
      logic [17:0] e;
      string tag;
      speed   = VEC[r][34];
      cur_per = int'(VEC[r][33:30]);
      cur_pat = VEC[r][29:18];
      e       = VEC[r][17:0];
      tag = (e == 18'h0) ? "R2" : (e == 18'h1FFFF) ? "R5" :
            (e == 18'h20000) ? "R6" : "R4";
      do_reset();
      run(6, 5, e, tag, 1'b1);
    end

    // R8: step from all ones to a -1/2 pattern in the middle of a conversion
    speed = 1'b1; cur_per = 1; cur_pat = 12'h001;
    do_reset();
    run(6, 5, 18'h1FFFF, "R5", 1'b1);
    drive(FR / 2);
    cur_per = 4; cur_pat = 12'h001; idx = 0;
    run(5, 5, 18'h2BC00, "R8", 1'b0);

    // R9: fast to slow at a boundary, then slow to fast mid-conversion
    speed = 1'b1; cur_per = 4; cur_pat = 12'h007;
    do_reset();
    run(6, 5, 18'h14400, "R9", 1'b1);
    idle();
    speed = 1'b0;
    idle();
    run(6, 5, 18'h14400, "R9", 1'b1);
    drive(10);
    idle();
    speed = 1'b1;
    cur_pat = 12'h001;
    idle();
    run(6, 5, 18'h2BC00, "R9", 1'b1);

    finish_run();
  end
endmodule